// File: doc/BRIEF.md
# Capture/Compare Interval Timer

A single counter peripheral with a small register window on a synchronous register bus. Software writes a control word, a preset value and reads back the live count. In generate mode the counter steps up or down once per clock while running. When it reaches its terminal value it raises a status flag and either reloads the preset or stops. In capture mode the counter keeps stepping, and a rising edge on an external trigger copies the live count into the preset register and raises the same flag.

The status flag sits at bit 23 of the control word. Software clears it by writing a 1 there. The interrupt line is high while the flag is set and the interrupt enable bit is on.

Address map: 0 holds the control word, 1 the preset, 2 the live count, which is read-only. Address 3 reads zero.

Control bits:

| Bit | Name | Meaning |
|-----|------|---------|
| 0 | capture select | 1 = capture mode, 0 = generate mode |
| 1 | down | 1 = count down, 0 = count up |
| 2 | auto-reload | reload the preset at the terminal value |
| 3 | force preset | copy the preset into the counter every cycle while set |
| 4 | interrupt enable | lets the flag drive the interrupt line |
| 5 | run | counter steps while set |
| 23 | flag | set by hardware; a written 1 clears it |

Top module: `cap_timer`

## Requirements
- R1: After reset the control word, flag, preset and count all read 0 and `irq` is low.
- R2: In generate mode with run (bit 5) set, the count changes by exactly one per clock. It rises when down (bit 1) is 0 and falls when it is 1.
- R3: In generate mode the flag (bit 23) is set by the cycle that finds the count at its terminal value. The terminal value is all ones when counting up and zero when counting down.
- R4: At the terminal value with auto-reload (bit 2) set, the counter takes the preset value. With auto-reload clear, the count holds at the terminal value and the run bit reads back 0.
- R5: In capture mode (bit 0 = 1) with run set, a rising edge on `cap_trig` passes two synchronising flops and an edge detector. It then copies the count into the preset register and sets the flag; both are visible three clock edges after the input rises.
- R6: With run clear, or with `cap_trig` held low, no capture takes place and the flag stays 0.
- R7: While force preset (bit 3) is set, the count equals the preset value and does not step.
- R8: A control write with bit 23 = 1 clears the flag. A control write with bit 23 = 0 leaves the flag unchanged. Bits 5..0 take the written value.
- R9: `irq` is high exactly while the flag and interrupt enable (bit 4) are both 1, and it stays high until the flag is cleared or the enable is removed.
- R10: Writes to the count address (2) have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| cap_trig | input | 1 | Asynchronous capture trigger |
| irq | output | 1 | Level interrupt |

## Verification
Register writes take effect at the clock edge that samples them. A count started with a run write has advanced by N after N further edges, and a terminal event shows in the flag one edge after the count reaches the terminal value. Capture results trail the trigger by three edges because of the two synchroniser flops and the edge register. `irq` and read data are combinational, so they follow the same edge as the flag and registers. The bench drives inputs on falling edges and reads one time unit later, counting the rising edges from each write to place each check on the exact cycle its result is due.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cap_trig,
  output logic          irq
);
  localparam int B_CAP  = 0;
  localparam int B_DOWN = 1;
  localparam int B_ARL  = 2;
  localparam int B_LD   = 3;
  localparam int B_IEN  = 4;
  localparam int B_RUN  = 5;
  localparam int B_FLAG = 23;
  localparam int NCTL   = 6;

  logic [NCTL-1:0] ctl_q;
  logic [DW-1:0]   pre_q, cnt_q;
  logic            flag_q;
  logic [2:0]      sync_q;

  wire wr_ctl   = reg_we && reg_addr == 2'd0;
  wire wr_pre   = reg_we && reg_addr == 2'd1;
  wire running  = ctl_q[B_RUN];
  wire at_term  = ctl_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == '1);
  wire gen_roll = running && !ctl_q[B_CAP] && !ctl_q[B_LD] && at_term;
  wire trig_rise = sync_q[1] && !sync_q[2];
  wire cap_hit  = running && ctl_q[B_CAP] && trig_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], cap_trig};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= reg_wdata[NCTL-1:0];
      if (gen_roll && !ctl_q[B_ARL]) ctl_q[B_RUN] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (cap_hit) pre_q <= cnt_q;
    else if (wr_pre)  pre_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ctl_q[B_LD]) begin
      cnt_q <= pre_q;
    end else if (running) begin
      if (gen_roll) begin
        if (ctl_q[B_ARL]) cnt_q <= pre_q;
      end else begin
        cnt_q <= ctl_q[B_DOWN] ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           flag_q <= 1'b0;
    else if (gen_roll || cap_hit)         flag_q <= 1'b1;
    else if (wr_ctl && reg_wdata[B_FLAG]) flag_q <= 1'b0;
  end

  assign irq = flag_q && ctl_q[B_IEN];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[NCTL-1:0] = ctl_q;
        reg_rdata[B_FLAG]   = flag_q;
      end
      2'd1:    reg_rdata = pre_q;
      2'd2:    reg_rdata = cnt_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata,
  input logic          irq,
  input logic [5:0]    ctl_q,
  input logic [DW-1:0] pre_q,
  input logic [DW-1:0] cnt_q,
  input logic          flag_q
);
  wire clr_wr = reg_we && reg_addr == 2'd0 && reg_wdata[23];
  wire ien_off_wr = reg_we && reg_addr == 2'd0 && !reg_wdata[4];

  AST_FLAG_CLEAR_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_wr)); // R8

  AST_GEN_FLAG_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) && !$past(ctl_q[0]) |-> ($past(cnt_q) == '1 || $past(cnt_q) == '0)); // R3

  AST_CAPTURE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) && $past(ctl_q[0]) |-> $past(ctl_q[5])); // R5

  AST_FORCE_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[3] |=> cnt_q == $past(pre_q)); // R7

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_wr && !ien_off_wr |=> irq); // R9

  AST_STOPPED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[5] && !ctl_q[3] |=> $stable(cnt_q)); // R10
endmodule

bind cap_timer cap_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .irq(irq), .ctl_q(ctl_q), .pre_q(pre_q),
  .cnt_q(cnt_q), .flag_q(flag_q)
);

// File: tb/sim_cap_timer.sv
module sim_cap_timer;
  localparam int PERIOD = 10;
  localparam int NV = 4;
  localparam logic [31:0] CAP = 32'h1, DOWN = 32'h2, ARL = 32'h4, LD = 32'h8,
                          IEN = 32'h10, RUN = 32'h20, FLAG = 32'h0080_0000;
  localparam logic [31:0] V_PRE [NV] = '{32'd100, 32'd50, 32'd3, 32'd0};
  localparam logic [31:0] V_CTL [NV] = '{32'h20, 32'h22, 32'h22, 32'h20};
  localparam int          V_CYC [NV] = '{7, 10, 2, 20};
  localparam logic [31:0] V_EXP [NV] = '{32'd107, 32'd40, 32'd1, 32'd20};

  logic clk = 0, rst_n = 0, reg_we = 0, cap_trig = 0, irq;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, rv;
  int n_run = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  cap_timer u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_trig(cap_trig), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic start(input logic [31:0] pre, input logic [31:0] ctl);
    wr(2'd1, pre); wr(2'd0, LD); wr(2'd0, ctl);
  endtask

  initial begin
    #(PERIOD*100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, rv); check("R1 ctrl", rv, 0);
    rd(2'd1, rv); check("R1 preset", rv, 0);
    rd(2'd2, rv); check("R1 count", rv, 0);
    check("R1 irq", {31'b0, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      start(V_PRE[i], V_CTL[i]);
      repeat (V_CYC[i]) @(negedge clk);
      rd(2'd2, rv); check("R2 count step", rv, V_EXP[i]);
      wr(2'd0, 0);
    end

    // R7: preset forced while load bit held
    wr(2'd1, 32'd77); wr(2'd0, LD | RUN);
    repeat (4) @(negedge clk);
    rd(2'd2, rv); check("R7 forced", rv, 32'd77);
    wr(2'd0, 0);

    // R3/R4 reload going up
    start(32'hFFFF_FFFD, RUN | ARL);
    repeat (2) @(negedge clk);
    rd(2'd0, rv); check("R3 no flag yet", rv & FLAG, 0);
    @(negedge clk);
    rd(2'd0, rv); check("R3 flag up", rv & FLAG, FLAG);
    rd(2'd2, rv); check("R4 reload", rv, 32'hFFFF_FFFD);
    wr(2'd0, FLAG);
    rd(2'd0, rv); check("R8 cleared", rv & FLAG, 0);

    // R3/R4 down, no reload: hold at zero, run cleared
    start(32'd1, RUN | DOWN | IEN);
    repeat (4) @(negedge clk);
    rd(2'd2, rv); check("R4 hold", rv, 0);
    rd(2'd0, rv); check("R4 run off", rv, FLAG | IEN | DOWN);
    check("R9 irq on", {31'b0, irq}, 1);
    wr(2'd0, IEN | DOWN);
    rd(2'd0, rv); check("R8 write0 keeps", rv & FLAG, FLAG);
    check("R9 irq stays", {31'b0, irq}, 1);
    wr(2'd0, FLAG | IEN);
    check("R9 irq off", {31'b0, irq}, 0);
    rd(2'd0, rv); check("R8 bits", rv, IEN);

    // R10: count address not writable
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, rv); check("R10 ignored", rv, 0);

    // R6: capture disabled or trigger low
    wr(2'd0, CAP);
    cap_trig = 1; repeat (5) @(negedge clk); cap_trig = 0;
    repeat (3) @(negedge clk);
    rd(2'd0, rv); check("R6 no run", rv & FLAG, 0);
    start(32'd500, RUN | CAP);
    repeat (6) @(negedge clk);
    rd(2'd0, rv); check("R6 trig low", rv & FLAG, 0);
    rd(2'd1, rv); check("R6 preset kept", rv, 32'd500);
    wr(2'd0, 0);

    // R5: capture three edges after trigger rise
    start(32'd1000, RUN | CAP);
    cap_trig = 1;
    repeat (2) @(negedge clk);
    rd(2'd0, rv); check("R5 not yet", rv & FLAG, 0);
    @(negedge clk);
    rd(2'd0, rv); check("R5 flag", rv & FLAG, FLAG);
    rd(2'd1, rv); check("R5 captured", rv, 32'd1002);
    repeat (3) @(negedge clk);
    rd(2'd1, rv); check("R5 single edge", rv, 32'd1002);
    cap_trig = 0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule